// File: doc/BRIEF.md
# Domain-Tagged Write Fence Tracker

This block keeps count of memory writes that are still in flight, split by physical synchronization domain, and decides when a fence may retire. Each issuing context names a logical domain: default (encoding 0) or remote (encoding 1). A small per-context table turns that logical domain into a physical domain number. Every accepted write leaves the block carrying that physical domain and an epoch bit. The fabric hands both back with the acknowledgement, and the block decrements the matching counter.

A device-scope fence waits only on its own physical domain. A system-scope fence waits on every domain. When a fence is accepted, the epoch of each domain it covers flips. From then on the fence waits only on the counter of the previous epoch. Writes issued after acceptance go into the new epoch, so they never lengthen the wait. Only one fence is in flight at a time.

When the block is built with a single domain, every tag collapses to 0.

Top module: `dom_fence_tracker`

## Requirements
- R1: The tracker supports NUM_DOM physical domains, 4 by default. Any physical domain value written to the map that is not below NUM_DOM is stored as 0. With NUM_DOM = 1, every tag is therefore 0.
- R2: After reset:
  - every context maps logical 0 (default) to physical 0;
  - every context maps logical 1 (remote) to physical 1, or to 0 when NUM_DOM = 1;
  - `fn_rdy` is 1, `fn_done` is 0 and `wr_rdy` is 1.
- R3: A map write takes effect from the next cycle. A lookup in the same cycle still sees the old entry. Both logical domains of a context may map to the same physical domain.
- R4: `wr_pdom` and `wr_epoch` are combinational lookups of the current `wr_ctx`/`wr_ldom`. An accepted write (`wr_vld && wr_rdy`) increments the counter of that domain and epoch. An acknowledgement decrements the counter named by `ack_pdom`/`ack_epoch`.
- R5: After acceptance, a device-scope fence (`fn_sys` = 0) raises `fn_done` in the first cycle in which its domain holds no write from before the fence. Outstanding writes in other domains do not hold it back. With nothing pending, `fn_done` rises in the cycle right after acceptance.
- R6: Writes accepted in the fence's acceptance cycle belong to the fence's wait. Writes accepted later carry the other epoch value and do not delay the fence.
- R7: A system-scope fence (`fn_sys` = 1) raises `fn_done` only once no domain holds a write from before the fence.
- R8: `fn_done` is a single-cycle pulse. `fn_rdy` is 0 from the cycle after acceptance through the done cycle, and returns to 1 in the cycle after `fn_done`.
- R9: `wr_rdy` is 0 while the counter for the addressed domain and current epoch equals 2^CNT_W-1. An acknowledgement in the same cycle does not release it. Other domains remain ready.
- R10: A write accepted and a write acknowledged for the same domain and epoch in the same cycle leave that counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 1 | Write issue request |
| wr_ctx | input | CTX_W | Issuing context |
| wr_ldom | input | 1 | Logical domain (0 default, 1 remote) |
| wr_rdy | output | 1 | Write may be accepted |
| wr_pdom | output | DOM_W | Physical domain tag for the write |
| wr_epoch | output | 1 | Epoch tag for the write |
| ack_vld | input | 1 | Write acknowledgement |
| ack_pdom | input | DOM_W | Returned physical domain tag |
| ack_epoch | input | 1 | Returned epoch tag |
| fn_vld | input | 1 | Fence request |
| fn_rdy | output | 1 | Fence may be accepted |
| fn_sys | input | 1 | 1 system scope, 0 device scope |
| fn_ctx | input | CTX_W | Fence context |
| fn_ldom | input | 1 | Fence logical domain |
| fn_done | output | 1 | Fence completion pulse |
| cfg_we | input | 1 | Map write strobe |
| cfg_ctx | input | CTX_W | Map entry context |
| cfg_ldom | input | 1 | Map entry logical domain |
| cfg_pdom | input | DOM_W | Physical domain to store |

## Verification
A write issue and an acknowledgement can land on the same domain counter in the same cycle. The bench provokes this in two situations.

- **Counter one below saturation.** After the simultaneous issue and acknowledgement, the counter must stay one below full. This is judged through `wr_rdy`: it must still be 1, and a single further write must drop it to 0.
- **Counter at saturation.** The blocked issue must stay refused even though the acknowledgement frees a slot. `wr_rdy` must remain 0 during that cycle and return to 1 only afterwards.

Fence acceptance meeting late writes is judged the same way. A write made after acceptance must not keep `fn_done` low.

// File: rtl/fence_trk_pkg.sv
package fence_trk_pkg;

    typedef enum logic {
        LDOM_DEFAULT = 1'b0,
        LDOM_REMOTE  = 1'b1
    } ldom_e;

    typedef enum logic {
        FST_IDLE = 1'b0,
        FST_WAIT = 1'b1
    } fst_e;

    // index width for a table of n entries, never below one bit
    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dom_map_table.sv
module dom_map_table
    import fence_trk_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int NUM_CTX = 8,
    localparam int DOM_W = idx_w(NUM_DOM),
    localparam int CTX_W = idx_w(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CTX_W-1:0] cfg_ctx,
    input  logic             cfg_ldom,
    input  logic [DOM_W-1:0] cfg_pdom,
    input  logic [CTX_W-1:0] a_ctx,
    input  logic             a_ldom,
    output logic [DOM_W-1:0] a_pdom,
    input  logic [CTX_W-1:0] b_ctx,
    input  logic             b_ldom,
    output logic [DOM_W-1:0] b_pdom
);

    localparam logic [DOM_W-1:0] RST_REMOTE = (NUM_DOM > 1) ? DOM_W'(1) : '0;

    logic [DOM_W-1:0] tbl [NUM_CTX][2];

    // out-of-range physical domains fold onto domain 0
    function automatic logic [DOM_W-1:0] fold(logic [DOM_W-1:0] v);
        return (int'(v) < NUM_DOM) ? v : '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                tbl[c][LDOM_DEFAULT] <= '0;
                tbl[c][LDOM_REMOTE]  <= RST_REMOTE;
            end
        end else if (cfg_we) begin
            tbl[cfg_ctx][cfg_ldom] <= fold(cfg_pdom);
        end
    end

    assign a_pdom = tbl[a_ctx][a_ldom];
    assign b_pdom = tbl[b_ctx][b_ldom];

    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(a_pdom) < NUM_DOM);                                          // R1

    AST_CFG_NEXT: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_we) && !$past(rst) && a_ctx == $past(cfg_ctx) && a_ldom == $past(cfg_ldom))
        |-> a_pdom == fold($past(cfg_pdom)));                             // R3

endmodule

// File: rtl/dom_out_ctr.sv
module dom_out_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign full = &cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |-> !full);                                         // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |-> cnt != '0);                                     // R4

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(cnt));                                   // R10

endmodule

// File: rtl/fence_waiter.sv
module fence_waiter
    import fence_trk_pkg::*;
#(
    parameter int NUM_DOM = 4,
    localparam int DOM_W = idx_w(NUM_DOM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_vld,
    input  logic               req_sys,
    input  logic [DOM_W-1:0]   req_dom,
    output logic               req_rdy,
    input  logic [NUM_DOM-1:0] old_zero,
    output logic [NUM_DOM-1:0] cur_ep,
    output logic               done
);

    typedef struct packed {
        logic             sys;
        logic [DOM_W-1:0] dom;
    } fcap_t;

    fst_e               st;
    fcap_t              cap;
    logic               accept;
    logic               drained;
    logic [NUM_DOM-1:0] flip_mask;

    assign req_rdy = (st == FST_IDLE);
    assign accept  = req_vld && req_rdy;

    always_comb begin
        flip_mask = '0;
        if (accept) begin
            if (req_sys) flip_mask = '1;
            else         flip_mask = NUM_DOM'(1) << req_dom;
        end
    end

    assign drained = cap.sys ? (&old_zero) : old_zero[cap.dom];
    assign done    = (st == FST_WAIT) && drained;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FST_IDLE;
            cap    <= '0;
            cur_ep <= '0;
        end else begin
            cur_ep <= cur_ep ^ flip_mask;
            if (accept) begin
                st  <= FST_WAIT;
                cap <= '{sys: req_sys, dom: req_dom};
            end else if (done) begin
                st <= FST_IDLE;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R8

    AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> req_rdy);                                                // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_rdy);                                             // R8

endmodule

// File: rtl/dom_fence_tracker.sv
module dom_fence_tracker
    import fence_trk_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int NUM_CTX = 8,
    parameter int CNT_W   = 8,
    localparam int DOM_W = idx_w(NUM_DOM),
    localparam int CTX_W = idx_w(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_vld,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic             wr_ldom,
    output logic             wr_rdy,
    output logic [DOM_W-1:0] wr_pdom,
    output logic             wr_epoch,
    input  logic             ack_vld,
    input  logic [DOM_W-1:0] ack_pdom,
    input  logic             ack_epoch,
    input  logic             fn_vld,
    output logic             fn_rdy,
    input  logic             fn_sys,
    input  logic [CTX_W-1:0] fn_ctx,
    input  logic             fn_ldom,
    output logic             fn_done,
    input  logic             cfg_we,
    input  logic [CTX_W-1:0] cfg_ctx,
    input  logic             cfg_ldom,
    input  logic [DOM_W-1:0] cfg_pdom
);

    logic [DOM_W-1:0]   fn_pdom;
    logic [NUM_DOM-1:0] cur_ep;
    logic [NUM_DOM-1:0] old_zero;
    logic [CNT_W-1:0]   cnt  [NUM_DOM][2];
    logic [1:0]         full [NUM_DOM];
    logic               wr_fire;

    dom_map_table #(.NUM_DOM(NUM_DOM), .NUM_CTX(NUM_CTX)) i_map (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_ctx  (cfg_ctx),
        .cfg_ldom (cfg_ldom),
        .cfg_pdom (cfg_pdom),
        .a_ctx    (wr_ctx),
        .a_ldom   (wr_ldom),
        .a_pdom   (wr_pdom),
        .b_ctx    (fn_ctx),
        .b_ldom   (fn_ldom),
        .b_pdom   (fn_pdom)
    );

    fence_waiter #(.NUM_DOM(NUM_DOM)) i_fence (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (fn_vld),
        .req_sys  (fn_sys),
        .req_dom  (fn_pdom),
        .req_rdy  (fn_rdy),
        .old_zero (old_zero),
        .cur_ep   (cur_ep),
        .done     (fn_done)
    );

    assign wr_epoch = cur_ep[wr_pdom];
    assign wr_rdy   = !full[wr_pdom][wr_epoch];
    assign wr_fire  = wr_vld && wr_rdy;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        for (genvar e = 0; e < 2; e++) begin : g_ep
            logic inc;
            logic dec;
            assign inc = wr_fire && (wr_pdom == DOM_W'(d)) && (wr_epoch == 1'(e));
            assign dec = ack_vld && (ack_pdom == DOM_W'(d)) && (ack_epoch == 1'(e));
            dom_out_ctr #(.CNT_W(CNT_W)) i_ctr (
                .clk  (clk),
                .rst  (rst),
                .inc  (inc),
                .dec  (dec),
                .cnt  (cnt[d][e]),
                .full (full[d][e])
            );
        end
        // the epoch not currently handed out holds pre-fence writes
        assign old_zero[d] = cur_ep[d] ? (cnt[d][0] == '0) : (cnt[d][1] == '0);
    end

    AST_IDLE_OLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        fn_rdy |-> (&old_zero));                                          // R6

    AST_ACK_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> int'(ack_pdom) < NUM_DOM);                            // R4

endmodule

// File: tb/test_dom_fence_tracker.sv
module test_dom_fence_tracker;

    localparam int ND = 4;
    localparam int NC = 4;
    localparam int CW = 3;
    localparam int SAT = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_vld, wr_ldom, wr_rdy, wr_epoch;
    logic [1:0] wr_ctx, wr_pdom;
    logic       ack_vld, ack_epoch;
    logic [1:0] ack_pdom;
    logic       fn_vld, fn_rdy, fn_sys, fn_ldom, fn_done;
    logic [1:0] fn_ctx;
    logic       cfg_we, cfg_ldom;
    logic [1:0] cfg_ctx, cfg_pdom;

    logic       s_rdy, s_ep, s_frdy, s_done;
    logic [0:0] s_pdom;

    int checks = 0;
    int errors = 0;
    int exp_map [NC][2];

    always #10 clk = ~clk;

    dom_fence_tracker #(.NUM_DOM(ND), .NUM_CTX(NC), .CNT_W(CW)) i_dom_fence_tracker (
        .clk(clk), .rst(rst),
        .wr_vld(wr_vld), .wr_ctx(wr_ctx), .wr_ldom(wr_ldom), .wr_rdy(wr_rdy),
        .wr_pdom(wr_pdom), .wr_epoch(wr_epoch),
        .ack_vld(ack_vld), .ack_pdom(ack_pdom), .ack_epoch(ack_epoch),
        .fn_vld(fn_vld), .fn_rdy(fn_rdy), .fn_sys(fn_sys), .fn_ctx(fn_ctx),
        .fn_ldom(fn_ldom), .fn_done(fn_done),
        .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_ldom(cfg_ldom), .cfg_pdom(cfg_pdom)
    );

    dom_fence_tracker #(.NUM_DOM(1), .NUM_CTX(NC), .CNT_W(CW)) i_dom_fence_tracker_one (
        .clk(clk), .rst(rst),
        .wr_vld(1'b0), .wr_ctx(wr_ctx), .wr_ldom(wr_ldom), .wr_rdy(s_rdy),
        .wr_pdom(s_pdom), .wr_epoch(s_ep),
        .ack_vld(1'b0), .ack_pdom(1'b0), .ack_epoch(1'b0),
        .fn_vld(1'b0), .fn_rdy(s_frdy), .fn_sys(1'b0), .fn_ctx(2'd0),
        .fn_ldom(1'b0), .fn_done(s_done),
        .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_ldom(cfg_ldom), .cfg_pdom(cfg_pdom[0:0])
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_vld = 0; wr_ctx = 0; wr_ldom = 0;
        ack_vld = 0; ack_pdom = 0; ack_epoch = 0;
        fn_vld = 0; fn_sys = 0; fn_ctx = 0; fn_ldom = 0;
        cfg_we = 0; cfg_ctx = 0; cfg_ldom = 0; cfg_pdom = 0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic set_map(input int c, input int l, input int p);
        cfg_we = 1; cfg_ctx = 2'(c); cfg_ldom = 1'(l); cfg_pdom = 2'(p);
        tick();
        cfg_we = 0;
    endtask

    task automatic issue(input int c, input int l, output int d, output int e);
        wr_vld = 1; wr_ctx = 2'(c); wr_ldom = 1'(l);
        #1;
        d = int'(wr_pdom);
        e = int'(wr_epoch);
        chk("R9 ready before issue", int'(wr_rdy), 1);
        tick();
        wr_vld = 0;
    endtask

    task automatic ack(input int d, input int e);
        ack_vld = 1; ack_pdom = 2'(d); ack_epoch = 1'(e);
        tick();
        ack_vld = 0;
    endtask

    task automatic fence(input int sys, input int c, input int l);
        fn_vld = 1; fn_sys = 1'(sys); fn_ctx = 2'(c); fn_ldom = 1'(l);
        #1;
        chk("R8 fence ready", int'(fn_rdy), 1);
        tick();
        fn_vld = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d, e, e00, e01, en, e1a, e1b, e1c, el;

        // reset state and default map
        do_reset();
        #1;
        chk("R2 fn_rdy", int'(fn_rdy), 1);
        chk("R2 fn_done", int'(fn_done), 0);
        chk("R2 wr_rdy", int'(wr_rdy), 1);
        for (int c = 0; c < NC; c++) begin
            for (int l = 0; l < 2; l++) begin
                wr_ctx = 2'(c); wr_ldom = 1'(l);
                #1;
                chk("R2 reset map", int'(wr_pdom), l);
                chk("R1 single domain tag", int'(s_pdom), 0);
            end
        end

        // full map sweep
        for (int c = 0; c < NC; c++) begin
            for (int l = 0; l < 2; l++) begin
                exp_map[c][l] = (c + 2 * l + 1) % ND;
                set_map(c, l, exp_map[c][l]);
            end
        end
        for (int c = 0; c < NC; c++) begin
            for (int l = 0; l < 2; l++) begin
                wr_ctx = 2'(c); wr_ldom = 1'(l);
                #1;
                chk("R3 programmed map", int'(wr_pdom), exp_map[c][l]);
                chk("R1 single domain collapse", int'(s_pdom), 0);
            end
        end

        // same-cycle lookup sees old entry
        wr_ctx = 2'd2; wr_ldom = 1'b0;
        cfg_we = 1; cfg_ctx = 2'd2; cfg_ldom = 1'b0; cfg_pdom = 2'd0;
        #1;
        chk("R3 old entry same cycle", int'(wr_pdom), exp_map[2][0]);
        tick();
        cfg_we = 0;
        #1;
        chk("R3 new entry next cycle", int'(wr_pdom), 0);

        // both logical domains onto one physical domain
        set_map(3, 0, 2);
        set_map(3, 1, 2);
        wr_ctx = 2'd3;
        for (int l = 0; l < 2; l++) begin
            wr_ldom = 1'(l);
            #1;
            chk("R3 shared physical domain", int'(wr_pdom), 2);
        end

        // device fence isolation
        do_reset();
        issue(0, 0, d, e00); chk("R4 tag dom0", d, 0);
        issue(0, 0, d, e01); chk("R4 tag dom0", d, 0);
        issue(0, 1, d, e1a); chk("R4 tag dom1", d, 1);
        issue(0, 1, d, e1b);
        issue(0, 1, d, e1c);
        fence(0, 0, 0);
        chk("R5 fence pending", int'(fn_done), 0);
        chk("R8 busy after accept", int'(fn_rdy), 0);
        issue(0, 0, d, en);
        chk("R6 late write new epoch", (en == e00) ? 1 : 0, 0);
        ack(0, e00);
        chk("R5 one old write left", int'(fn_done), 0);
        ack(0, e01);
        chk("R5 device fence done with dom1 busy", int'(fn_done), 1);
        chk("R8 busy in done cycle", int'(fn_rdy), 0);
        tick();
        chk("R8 done single pulse", int'(fn_done), 0);
        chk("R8 ready after done", int'(fn_rdy), 1);

        // system fence waits on all domains
        fence(1, 0, 0);
        chk("R7 sys fence pending", int'(fn_done), 0);
        ack(0, en);
        chk("R7 dom1 still pending", int'(fn_done), 0);
        issue(0, 1, d, el);
        chk("R6 late dom1 write flipped", (el == e1a) ? 1 : 0, 0);
        ack(1, e1a);
        ack(1, e1b);
        chk("R7 one dom1 write left", int'(fn_done), 0);
        ack(1, e1c);
        chk("R7 sys fence done, late write ignored", int'(fn_done), 1);
        tick();
        chk("R8 pulse ends", int'(fn_done), 0);
        ack(1, el);

        // empty device fence
        fence(0, 1, 1);
        chk("R5 empty fence done next cycle", int'(fn_done), 1);
        tick();

        // saturation and same-cycle issue/ack
        do_reset();
        for (int i = 0; i < SAT; i++) issue(0, 1, d, e);
        wr_ctx = 2'd0; wr_ldom = 1'b1;
        #1;
        chk("R9 saturated", int'(wr_rdy), 0);
        wr_ldom = 1'b0;
        #1;
        chk("R9 other domain ready", int'(wr_rdy), 1);
        wr_vld = 1; wr_ldom = 1'b1;
        ack_vld = 1; ack_pdom = 2'd1; ack_epoch = 1'b0;
        #1;
        chk("R9 ack same cycle does not release", int'(wr_rdy), 0);
        tick();
        wr_vld = 0; ack_vld = 0;
        #1;
        chk("R9 released after ack", int'(wr_rdy), 1);
        wr_vld = 1;
        ack_vld = 1;
        tick();
        wr_vld = 0; ack_vld = 0;
        #1;
        chk("R10 issue+ack keep count", int'(wr_rdy), 1);
        issue(0, 1, d, e);
        wr_ldom = 1'b1;
        #1;
        chk("R10 one more fills", int'(wr_rdy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule